// File: doc/BRIEF.md
# Gated MAC Mode Control Register

This block holds the operating-mode bits of an Ethernet-style MAC in one 16-bit register. The register holds transmit and receive disables, a loopback enable, two loop-path selects, a force-collision request and a checksum-suppress bit. The write port is gated by the controller's run state. A write lands only while the controller is stopped or suspended, so the datapath never sees its mode change while frames are moving. Reads are never gated.

From the stored bits the block derives several outputs. It decodes the loopback path and qualifies the force-collision request against that path. It also forces full duplex whenever any loop path is chosen. Two run flags, transmitter-on and receiver-on, are set by a start command for each direction that is not disabled. Stop clears the run flags but keeps the stored mode. Hard or soft reset clears both the register and the flags.

Top module: `mac_mode_reg`

## Requirements
- R1: A read at address MODE_ADDR (default 8'h3C) returns the register with bit 0 tx_off, bit 1 rx_off, bit 2 loop_en, bit 3 fcs_off, bit 4 coll_force, bit 5 int_sel, bit 6 media_sel and bits 15:7 as zero. Any other address reads zero. Reads ignore stop and suspend.
- R2: A write at MODE_ADDR while stop or suspend is high is visible from the next clock edge. A write to any other address leaves the register unchanged.
- R3: A write while both stop and suspend are low leaves the register unchanged.
- R4: Hard reset or soft reset clears the register, tx_on and rx_on at the next edge, and reset wins over a write. Stop leaves every register bit, loop_en included, unchanged.
- R5: With stop low, a start pulse sets tx_on at the next edge when tx_off is 0. tx_on never sets when tx_off is 1, and it stays set after start falls.
- R6: With stop low, a start pulse sets rx_on at the next edge when rx_off is 0. rx_on never sets when rx_off is 1.
- R7: Stop high clears tx_on and rx_on at the next edge, and it blocks start in the same cycle.
- R8: lb_mode decodes {loop_en,int_sel,media_sel} as follows: 000 gives 0 (normal), 001 gives 1 (internal), 100 gives 2 (external), and every other pattern gives 3 (unsupported).
- R9: coll_force_en is 1 only when coll_force is 1 and lb_mode is internal. In every other mode, unsupported included, it is 0.
- R10: fdx_eff equals the fdx_cfg input when lb_mode is normal, and it is 1 in any other mode.
- R11: fcs_gen_en is the inverse of fcs_off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| stop | input | 1 | Controller stopped (level) |
| suspend | input | 1 | Controller suspended (level) |
| start | input | 1 | Start command |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 16 | Write data |
| fdx_cfg | input | 1 | Full-duplex setting from elsewhere |
| rdata | output | 16 | Read data |
| lb_mode | output | 2 | Decoded loop path |
| coll_force_en | output | 1 | Qualified force-collision enable |
| fdx_eff | output | 1 | Effective duplex |
| fcs_gen_en | output | 1 | Append checksum |
| tx_on | output | 1 | Transmitter running |
| rx_on | output | 1 | Receiver running |

## Verification
A corrupted mode bit appears on rdata and on the decoded outputs in the same cycle it is stored, because decoding is combinational. The bench therefore checks each write result one edge after the strobe. A faulty write gate shows as rdata moving during a write made while running, and this is visible at the next edge. Run-flag faults appear one edge after start or stop, so the bench samples the flags immediately after each start and stop pulse and again one cycle later.

// File: rtl/mac_mode_pkg.sv
package mac_mode_pkg;

    typedef struct packed {
        logic media_sel;
        logic int_sel;
        logic coll_force;
        logic fcs_off;
        logic loop_en;
        logic rx_off;
        logic tx_off;
    } mode_bits_t;

    localparam int MODE_W = $bits(mode_bits_t);

    typedef enum logic [1:0] {
        LB_NORMAL   = 2'd0,
        LB_INTERNAL = 2'd1,
        LB_EXTERNAL = 2'd2,
        LB_UNSUP    = 2'd3
    } lb_mode_t;

    function automatic lb_mode_t decode_lb(input logic loop_en,
                                           input logic int_sel,
                                           input logic media_sel);
        lb_mode_t m;
        case ({loop_en, int_sel, media_sel})
            3'b000:  m = LB_NORMAL;
            3'b001:  m = LB_INTERNAL;
            3'b100:  m = LB_EXTERNAL;
            default: m = LB_UNSUP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mode_regfile.sv
module mode_regfile
    import mac_mode_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h3C
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              wr_open,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output mode_bits_t        mode_q,
    output logic [REG_W-1:0]  rdata
);
    localparam int RSV_W = REG_W - MODE_W;

    logic hit;
    logic unused_rsv;

    assign hit        = (addr == MODE_ADDR);
    assign unused_rsv = ^wdata[REG_W-1:MODE_W];

    always_ff @(posedge clk) begin
        if (clr)
            mode_q <= '0;
        else if (wr_en && hit && wr_open)
            mode_q <= mode_bits_t'(wdata[MODE_W-1:0]);
    end

    always_comb begin
        rdata = '0;
        if (hit)
            rdata = {{RSV_W{1'b0}}, mode_q};
    end
endmodule

// File: rtl/mode_lb_decode.sv
module mode_lb_decode
    import mac_mode_pkg::*;
(
    input  mode_bits_t mode_q,
    input  logic       fdx_cfg,
    output lb_mode_t   lb_mode,
    output logic       coll_en,
    output logic       fdx_eff,
    output logic       fcs_gen_en
);
    always_comb begin
        lb_mode    = decode_lb(mode_q.loop_en, mode_q.int_sel, mode_q.media_sel);
        coll_en    = mode_q.coll_force && (lb_mode == LB_INTERNAL);
        fdx_eff    = (lb_mode == LB_NORMAL) ? fdx_cfg : 1'b1;
        fcs_gen_en = ~mode_q.fcs_off;
    end
endmodule

// File: rtl/mode_run_flags.sv
module mode_run_flags #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          stop,
    input  logic          start,
    input  logic [CH-1:0] dis,
    output logic [CH-1:0] on
);
    for (genvar i = 0; i < CH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (clr || stop)
                on[i] <= 1'b0;
            else if (start && !dis[i])
                on[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/mac_mode_reg.sv
module mac_mode_reg
    import mac_mode_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h3C
) (
    input  logic              clk,
    input  logic              hard_rst,
    input  logic              soft_rst,
    input  logic              stop,
    input  logic              suspend,
    input  logic              start,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              fdx_cfg,
    output logic [REG_W-1:0]  rdata,
    output logic [1:0]        lb_mode,
    output logic              coll_force_en,
    output logic              fdx_eff,
    output logic              fcs_gen_en,
    output logic              tx_on,
    output logic              rx_on
);
    localparam int RUN_CH = 2;

    mode_bits_t        mode_q;
    lb_mode_t          lb_dec;
    logic              clr;
    logic [RUN_CH-1:0] run_on;

    assign clr = hard_rst | soft_rst;

    mode_regfile #(.REG_W(REG_W), .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_regs (
        .clk(clk), .clr(clr), .wr_en(wr_en), .wr_open(stop | suspend),
        .addr(addr), .wdata(wdata), .mode_q(mode_q), .rdata(rdata)
    );

    mode_lb_decode u_dec (
        .mode_q(mode_q), .fdx_cfg(fdx_cfg), .lb_mode(lb_dec),
        .coll_en(coll_force_en), .fdx_eff(fdx_eff), .fcs_gen_en(fcs_gen_en)
    );

    mode_run_flags #(.CH(RUN_CH)) u_run (
        .clk(clk), .clr(clr), .stop(stop), .start(start),
        .dis({mode_q.rx_off, mode_q.tx_off}), .on(run_on)
    );

    assign lb_mode = lb_dec;
    assign tx_on   = run_on[0];
    assign rx_on   = run_on[1];
endmodule

// File: rtl/mac_mode_reg_chk.sv
module mac_mode_reg_chk
    import mac_mode_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h3C
) (
    input logic              clk,
    input logic              hard_rst,
    input logic              soft_rst,
    input logic              stop,
    input logic              suspend,
    input logic              start,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       wdata,
    input logic [MODE_W-1:0] mode_q,
    input logic [1:0]        lb_mode,
    input logic              coll_force_en,
    input logic              fdx_eff,
    input logic              tx_on,
    input logic              rx_on
);
    logic rst;
    assign rst = hard_rst | soft_rst;

    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == MODE_ADDR && (stop || suspend)) |=> (mode_q == $past(wdata[MODE_W-1:0])));

    a_r3_write_gated: assert property (@(posedge clk) disable iff (rst)
        (!stop && !suspend) |=> $stable(mode_q));

    a_r4_reset_clears: assert property (@(posedge clk)
        rst |=> (mode_q == '0 && !tx_on && !rx_on));

    a_r5_tx_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_on) |-> ($past(start) && !$past(mode_q[0])));

    a_r6_rx_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_on) |-> ($past(start) && !$past(mode_q[1])));

    a_r7_stop_drops_flags: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!tx_on && !rx_on));

    a_r9_coll_qualified: assert property (@(posedge clk) disable iff (rst)
        coll_force_en |-> (lb_mode == LB_INTERNAL));

    a_r10_loop_full_duplex: assert property (@(posedge clk) disable iff (rst)
        (lb_mode != LB_NORMAL) |-> fdx_eff);
endmodule

bind mac_mode_reg mac_mode_reg_chk #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_chk (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .stop(stop),
    .suspend(suspend), .start(start), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .mode_q(mode_q), .lb_mode(lb_mode),
    .coll_force_en(coll_force_en), .fdx_eff(fdx_eff), .tx_on(tx_on), .rx_on(rx_on)
);

// File: tb/tb_mac_mode_reg.sv
`timescale 1ns/1ps
module tb_mac_mode_reg;
    localparam logic [7:0] MA = 8'h3C;
    localparam int NV = 8;
    // {bits[6:0], lb_mode[1:0], coll_force_en, fdx_eff with fdx_cfg=0}
    localparam logic [10:0] VEC [NV] = '{
        {7'h00, 2'd0, 1'b0, 1'b0},
        {7'h40, 2'd1, 1'b0, 1'b1},
        {7'h50, 2'd1, 1'b1, 1'b1},
        {7'h14, 2'd2, 1'b0, 1'b1},
        {7'h20, 2'd3, 1'b0, 1'b1},
        {7'h30, 2'd3, 1'b0, 1'b1},
        {7'h54, 2'd3, 1'b0, 1'b1},
        {7'h18, 2'd0, 1'b0, 1'b0}
    };

    logic clk = 0;
    logic hard_rst = 1, soft_rst = 0, stop = 0, suspend = 0, start = 0, wr_en = 0, fdx_cfg = 0;
    logic [7:0] addr = MA;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0] lb_mode;
    logic coll_force_en, fdx_eff, fcs_gen_en, tx_on, rx_on;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mac_mode_reg dut (
        .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .stop(stop),
        .suspend(suspend), .start(start), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .fdx_cfg(fdx_cfg), .rdata(rdata), .lb_mode(lb_mode),
        .coll_force_en(coll_force_en), .fdx_eff(fdx_eff), .fcs_gen_en(fcs_gen_en),
        .tx_on(tx_on), .rx_on(rx_on)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; addr = MA;
        #1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        #1;
    endtask

    initial begin
        cyc(3);
        @(negedge clk); hard_rst = 0; #1;
        chk("R4 reset rdata", rdata, 16'h0000);
        chk("R4 reset flags", {14'd0, tx_on, rx_on}, 16'h0);
        chk("R8 reset lb_mode", {14'd0, lb_mode}, 16'h0);

        wr(MA, 16'h007F);
        chk("R3 write while running ignored", rdata, 16'h0000);

        suspend = 1;
        wr(MA, 16'hFFFF);
        chk("R2 suspend write, R1 reserved zero", rdata, 16'h007F);
        suspend = 0;
        addr = 8'h10; #1;
        chk("R1 other address reads zero", rdata, 16'h0000);
        addr = MA;
        stop = 1;
        wr(8'h3E, 16'h0000);
        chk("R2 other address write ignored", rdata, 16'h007F);

        for (int i = 0; i < NV; i++) begin
            wr(MA, {9'd0, VEC[i][10:4]});
            chk("R1 vector readback", rdata, {9'd0, VEC[i][10:4]});
            chk("R8 vector lb_mode", {14'd0, lb_mode}, {14'd0, VEC[i][3:2]});
            chk("R9 vector coll", {15'd0, coll_force_en}, {15'd0, VEC[i][1]});
            chk("R10 vector fdx", {15'd0, fdx_eff}, {15'd0, VEC[i][0]});
            chk("R11 vector fcs", {15'd0, fcs_gen_en}, {15'd0, ~VEC[i][7]});
        end
        fdx_cfg = 1; #1;
        chk("R10 normal passes fdx_cfg", {15'd0, fdx_eff}, 16'd1);
        fdx_cfg = 0;

        wr(MA, 16'h0002);
        stop = 0;
        pulse_start();
        chk("R5 tx_on set, R6 rx_on held off", {14'd0, tx_on, rx_on}, 16'b10);
        cyc(1);
        chk("R5 tx_on persists", {14'd0, tx_on, rx_on}, 16'b10);
        @(negedge clk); stop = 1;
        @(negedge clk); #1;
        chk("R7 stop clears flags", {14'd0, tx_on, rx_on}, 16'b00);
        start = 1; cyc(1); start = 0;
        chk("R7 stop blocks start", {14'd0, tx_on, rx_on}, 16'b00);
        wr(MA, 16'h0001);
        stop = 0;
        pulse_start();
        chk("R6 rx_on set, R5 tx_on held off", {14'd0, tx_on, rx_on}, 16'b01);

        stop = 1;
        wr(MA, 16'h0004);
        cyc(5);
        stop = 0; #1;
        chk("R4 stop keeps loop_en", rdata, 16'h0004);
        pulse_start();
        chk("R5 R6 both run", {14'd0, tx_on, rx_on}, 16'b11);
        @(negedge clk); soft_rst = 1;
        @(negedge clk); soft_rst = 0; #1;
        chk("R4 soft reset clears reg", rdata, 16'h0000);
        chk("R4 soft reset clears flags", {14'd0, tx_on, rx_on}, 16'b00);

        stop = 1;
        wr(MA, 16'h0044);
        @(negedge clk); hard_rst = 1; wr_en = 1; wdata = 16'h0010;
        @(negedge clk); hard_rst = 0; wr_en = 0; #1;
        chk("R4 hard reset beats write", rdata, 16'h0000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule